// File: doc/BRIEF.md
# Rate-Coded Spiking Crossbar Layer

This block is a cycle-based digital model of a single spiking layer with `N_IN` input rows and `M_OUT` output neurons. Every row-column crossing holds an unsigned weight. A run starts with a strobe that carries a spike count for each input row and a window length in clock cycles. Each row sends its spikes spread evenly over the window. In every cycle, each neuron adds the weights of the rows that spike in that cycle to its accumulator. When the accumulator reaches a threshold, the neuron fires, clears the accumulator and stays idle for a fixed dead time.

When the window closes, the block returns the number of times each neuron fired and raises `done` for one cycle. Inputs and outputs are both spike counts inside one window. Each fire costs dead time, so the output count rises less than linearly when the weighted drive is strong. Weights are written one at a time by row and column address between runs.

Top module: `spike_xbar_layer`

## Requirements
- R1: While the block is idle and `wr_en` is high, weight (`wr_row`, `wr_col`) takes `wr_val` at the clock edge. While busy, `wr_en` has no effect and every weight keeps its value.
- R2: A `start` seen while idle begins a run. It samples `in_count`, `win_len` and `threshold`, and clears every accumulator, dead-time counter and output count. A `start` seen while busy is ignored and does not change the run in progress.
- R3: A window of L cycles holds S = floor(L/2) slots, and slot k covers cycles 2k and 2k+1. A row spikes only in even cycles. Its effective count is c = min(count, S). A per-row phase p starts at 0. On each even cycle p+c is formed: if c is nonzero and p+c >= S, the row spikes and p becomes p+c-S; otherwise p becomes p+c. Each row therefore sends exactly c spikes.
- R4: In each window cycle, a neuron that is not in dead time forms its accumulator plus the sum of the weights of the rows spiking in that cycle. If the result is at least the threshold, the neuron fires: its count goes up by one and its accumulator becomes 0. Otherwise the accumulator takes the result.
- R5: After a fire, the neuron spends the next `DEAD_CYC` window cycles with its accumulator held at 0, ignoring input spikes. With `DEAD_CYC` = 0 it integrates again in the very next cycle.
- R6: Each output count saturates at 2^`OUT_W`-1 and never wraps.
- R7: `done` is high for exactly one cycle. That cycle directly follows the last window cycle, and `busy` is low in it. The counts then stay unchanged until the next accepted `start`.
- R8: After reset, `busy` and `done` are low, all counts are 0 and all weights are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight write strobe |
| wr_row | input | RW | Row address of the weight |
| wr_col | input | CW | Column address of the weight |
| wr_val | input | W_W | Weight value |
| start | input | 1 | Begin a run |
| in_count | input | N_IN*IN_W | Spike count per input row, row 0 in the low bits |
| win_len | input | WIN_W | Window length in cycles |
| threshold | input | THR_W | Firing threshold |
| busy | output | 1 | A window is running |
| done | output | 1 | One-cycle end-of-window pulse |
| spike_count | output | M_OUT*OUT_W | Fire count per neuron, neuron 0 in the low bits |

## Verification
The bench builds two copies of the layer: four rows, three neurons, 4-bit weights and 5-bit counts. One copy uses a dead time of two cycles and the other a dead time of zero, and both receive identical stimulus. This shows the dead-time compression and the undelayed refire side by side. The 5-bit counter is small enough that the zero-dead-time copy reaches saturation with an 80-cycle window. Window lengths sweep 10 to 80 in steps of 10. The counts include values above the slot count, so the clamp is exercised.

// File: rtl/spike_xbar_layer.sv
module spike_xbar_layer #(
  parameter int N_IN     = 4,
  parameter int M_OUT    = 3,
  parameter int W_W      = 4,
  parameter int IN_W     = 6,
  parameter int OUT_W    = 5,
  parameter int WIN_W    = 8,
  parameter int THR_W    = 8,
  parameter int DEAD_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [((N_IN>1)?$clog2(N_IN):1)-1:0]   wr_row,
  input  logic [((M_OUT>1)?$clog2(M_OUT):1)-1:0] wr_col,
  input  logic [W_W-1:0]           wr_val,
  input  logic                     start,
  input  logic [N_IN*IN_W-1:0]     in_count,
  input  logic [WIN_W-1:0]         win_len,
  input  logic [THR_W-1:0]         threshold,
  output logic                     busy,
  output logic                     done,
  output logic [M_OUT*OUT_W-1:0]   spike_count
);
  localparam int EW    = (IN_W > WIN_W) ? IN_W : WIN_W;
  localparam int SUM_W = ((THR_W > W_W) ? THR_W : W_W) + $clog2(N_IN + 1) + 1;
  localparam int DW    = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [OUT_W-1:0] OMAX = '1;

  logic [W_W-1:0]   wt    [N_IN][M_OUT];
  logic [WIN_W-1:0] len_r, cyc, slots;
  logic [THR_W-1:0] thr_r;
  logic [EW-1:0]    eff   [N_IN];
  logic [EW-1:0]    clamp [N_IN];
  logic [EW:0]      ph    [N_IN];
  logic [EW:0]      nxt   [N_IN];
  logic [N_IN-1:0]  spk;
  logic [SUM_W-1:0] acc   [M_OUT];
  logic [SUM_W-1:0] sum   [M_OUT];
  logic [DW-1:0]    dead  [M_OUT];
  logic [OUT_W-1:0] cnt   [M_OUT];
  logic [M_OUT-1:0] fire;

  wire             accept    = start && !busy;
  wire             last      = ({1'b0, cyc} + 1'b1) >= {1'b0, len_r};
  wire [WIN_W-1:0] new_slots = win_len >> 1;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      clamp[i] = (EW'(in_count[i*IN_W +: IN_W]) > EW'(new_slots)) ?
                 EW'(new_slots) : EW'(in_count[i*IN_W +: IN_W]);
      nxt[i]   = ph[i] + {1'b0, eff[i]};
      spk[i]   = busy && !cyc[0] && (eff[i] != '0) && (nxt[i] >= (EW+1)'(slots));
    end
  end

  always_comb begin
    for (int j = 0; j < M_OUT; j++) begin
      sum[j] = acc[j];
      for (int i = 0; i < N_IN; i++)
        if (spk[i]) sum[j] = sum[j] + SUM_W'(wt[i][j]);
      fire[j] = busy && (dead[j] == '0) && (sum[j] >= SUM_W'(thr_r));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++)
        for (int j = 0; j < M_OUT; j++) wt[i][j] <= '0;
    end else if (wr_en && !busy && (int'(wr_row) < N_IN) && (int'(wr_col) < M_OUT)) begin
      wt[wr_row][wr_col] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cyc   <= '0;
      len_r <= '0;
      slots <= '0;
      thr_r <= '0;
      for (int i = 0; i < N_IN; i++) begin
        eff[i] <= '0;
        ph[i]  <= '0;
      end
      for (int j = 0; j < M_OUT; j++) begin
        acc[j]  <= '0;
        dead[j] <= '0;
        cnt[j]  <= '0;
      end
    end else if (accept) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      cyc   <= '0;
      len_r <= win_len;
      slots <= new_slots;
      thr_r <= threshold;
      for (int i = 0; i < N_IN; i++) begin
        eff[i] <= clamp[i];
        ph[i]  <= '0;
      end
      for (int j = 0; j < M_OUT; j++) begin
        acc[j]  <= '0;
        dead[j] <= '0;
        cnt[j]  <= '0;
      end
    end else if (busy) begin
      cyc  <= cyc + 1'b1;
      busy <= !last;
      done <= last;
      if (!cyc[0])
        for (int i = 0; i < N_IN; i++)
          ph[i] <= spk[i] ? (nxt[i] - (EW+1)'(slots)) : nxt[i];
      for (int j = 0; j < M_OUT; j++) begin
        if (dead[j] != '0) begin
          dead[j] <= dead[j] - 1'b1;
          acc[j]  <= '0;
        end else if (fire[j]) begin
          acc[j]  <= '0;
          dead[j] <= DW'(DEAD_CYC);
          if (cnt[j] != OMAX) cnt[j] <= cnt[j] + 1'b1;
        end else begin
          acc[j] <= sum[j];
        end
      end
    end else begin
      done <= 1'b0;
    end
  end

  for (genvar j = 0; j < M_OUT; j++) begin : g_out
    assign spike_count[j*OUT_W +: OUT_W] = cnt[j];

    // R5
    dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dead[j] != '0) |=> (acc[j] == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !accept) |=> (cnt[j] == $past(cnt[j]) || cnt[j] == OUT_W'($past(cnt[j]) + 1'b1)));

    // R4
    acc_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fire[j] && dead[j] == '0) |=> (acc[j] < SUM_W'(thr_r)) || (thr_r == '0));

    for (genvar i = 0; i < N_IN; i++) begin : g_w
      // R1
      wt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wt[i][j]));
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  spike_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc[0] |-> (spk == '0));
endmodule

// File: tb/spike_xbar_layer_tb.sv
module spike_xbar_layer_tb;
  localparam int N = 4, M = 3, W_W = 4, IN_W = 6, OUT_W = 5, WIN_W = 8, THR_W = 8;
  localparam int OMAX = (1 << OUT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [1:0] wr_row = 0, wr_col = 0;
  logic [W_W-1:0] wr_val = 0;
  logic [N*IN_W-1:0] in_count = 0;
  logic [WIN_W-1:0] win_len = 0;
  logic [THR_W-1:0] threshold = 0;
  logic busy_a, done_a, busy_b, done_b;
  logic [M*OUT_W-1:0] cnt_a, cnt_b;

  int wm [N][M];
  int n_chk = 0, n_fail = 0;
  logic [M*OUT_W-1:0] q_a [$];
  logic [M*OUT_W-1:0] q_b [$];
  string q_t [$];
  logic [M*OUT_W-1:0] last_a;

  always #5 clk = ~clk;

  spike_xbar_layer #(.N_IN(N), .M_OUT(M), .W_W(W_W), .IN_W(IN_W), .OUT_W(OUT_W),
    .WIN_W(WIN_W), .THR_W(THR_W), .DEAD_CYC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_val(wr_val), .start(start), .in_count(in_count), .win_len(win_len),
    .threshold(threshold), .busy(busy_a), .done(done_a), .spike_count(cnt_a));

  spike_xbar_layer #(.N_IN(N), .M_OUT(M), .W_W(W_W), .IN_W(IN_W), .OUT_W(OUT_W),
    .WIN_W(WIN_W), .THR_W(THR_W), .DEAD_CYC(0)) u_dut_nd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_val(wr_val), .start(start), .in_count(in_count), .win_len(win_len),
    .threshold(threshold), .busy(busy_b), .done(done_b), .spike_count(cnt_b));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [M*OUT_W-1:0] model(logic [N*IN_W-1:0] cv, int L, int thr, int dd);
    int S, nx, s;
    int e [N];
    int p [N];
    int acc [M];
    int dt [M];
    int c [M];
    bit sp [N];
    logic [M*OUT_W-1:0] r;
    S = L / 2;
    for (int i = 0; i < N; i++) begin
      e[i] = int'(cv[i*IN_W +: IN_W]);
      if (e[i] > S) e[i] = S;
      p[i] = 0;
    end
    for (int j = 0; j < M; j++) begin
      acc[j] = 0; dt[j] = 0; c[j] = 0;
    end
    for (int cy = 0; cy < L; cy++) begin
      for (int i = 0; i < N; i++) begin
        sp[i] = 0;
        if (cy % 2 == 0) begin
          nx = p[i] + e[i];
          if (e[i] != 0 && nx >= S) begin
            sp[i] = 1; p[i] = nx - S;
          end else p[i] = nx;
        end
      end
      for (int j = 0; j < M; j++) begin
        if (dt[j] > 0) begin
          dt[j]--; acc[j] = 0;
        end else begin
          s = acc[j];
          for (int i = 0; i < N; i++) if (sp[i]) s += wm[i][j];
          if (s >= thr) begin
            if (c[j] < OMAX) c[j]++;
            acc[j] = 0; dt[j] = dd;
          end else acc[j] = s;
        end
      end
    end
    for (int j = 0; j < M; j++) r[j*OUT_W +: OUT_W] = OUT_W'(c[j]);
    return r;
  endfunction

  function automatic logic [N*IN_W-1:0] pack(int a, int b, int c, int d);
    return {IN_W'(d), IN_W'(c), IN_W'(b), IN_W'(a)};
  endfunction

  task automatic load_w(input int r, input int c, input int v);
    @(negedge clk);
    wr_en = 1; wr_row = 2'(r); wr_col = 2'(c); wr_val = W_W'(v);
    @(negedge clk);
    wr_en = 0;
    wm[r][c] = v;
  endtask

  task automatic wait_idle();
    while (busy_a || busy_b) @(negedge clk);
    repeat (3) @(negedge clk);
    // R7: counts hold after done
    check("R7 hold", int'(cnt_a), int'(last_a));
  endtask

  task automatic run(input int L, input int thr, input logic [N*IN_W-1:0] cv, input string tag);
    q_a.push_back(model(cv, L, thr, 2));
    q_b.push_back(model(cv, L, thr, 0));
    q_t.push_back(tag);
    @(negedge clk);
    in_count = cv; win_len = WIN_W'(L); threshold = THR_W'(thr); start = 1;
    @(negedge clk);
    start = 0;
    wait_idle();
  endtask

  always @(negedge clk) begin
    if (done_a || done_b) begin
      string t;
      logic [M*OUT_W-1:0] ea, eb;
      check("R7 done align", int'(done_a && done_b), 1);
      check("R7 busy low at done", int'(busy_a || busy_b), 0);
      if (q_t.size() == 0) begin
        check("R2 unexpected done", 1, 0);
      end else begin
        t = q_t.pop_front(); ea = q_a.pop_front(); eb = q_b.pop_front();
        last_a = ea;
        for (int j = 0; j < M; j++) begin
          check({t, " dead2"}, int'(cnt_a[j*OUT_W +: OUT_W]), int'(ea[j*OUT_W +: OUT_W]));
          check({t, " dead0 R5"}, int'(cnt_b[j*OUT_W +: OUT_W]), int'(eb[j*OUT_W +: OUT_W]));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [M*OUT_W-1:0] ea;
    for (int i = 0; i < N; i++) for (int j = 0; j < M; j++) wm[i][j] = 0;
    last_a = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8
    check("R8 busy", int'(busy_a), 0);
    check("R8 done", int'(done_a), 0);
    check("R8 counts", int'(cnt_a), 0);
    // R8/R1: zero weights give no fires
    run(40, 1, pack(20, 20, 20, 20), "R8 zero weights");

    // R1 load weights
    load_w(0, 0, 3); load_w(1, 0, 5); load_w(2, 0, 1); load_w(3, 0, 7);
    load_w(0, 1, 15); load_w(1, 1, 0); load_w(2, 1, 9); load_w(3, 1, 2);
    load_w(0, 2, 1); load_w(1, 2, 1); load_w(2, 2, 1); load_w(3, 2, 1);

    run(40, 10, pack(5, 12, 3, 20), "R4 mix");
    for (int L = 10; L <= 80; L += 10)
      run(L, 8, pack(L / 4, L / 3, 1, L / 2), "R3 sweep");
    run(20, 6, pack(63, 40, 11, 0), "R3 clamp");
    run(80, 255, pack(2, 2, 2, 2), "R4 high thr");
    run(30, 0, pack(0, 0, 0, 0), "R4 zero thr");

    // R6 saturation
    load_w(0, 0, 15); load_w(0, 1, 15); load_w(0, 2, 15);
    run(80, 1, pack(63, 63, 63, 63), "R6 saturate");
    run(80, 20, pack(40, 40, 40, 40), "R5 drive");

    // R1/R2: writes and start during a run are ignored
    ea = model(pack(7, 9, 4, 11), 60, 12, 2);
    q_a.push_back(ea);
    q_b.push_back(model(pack(7, 9, 4, 11), 60, 12, 0));
    q_t.push_back("R1 R2 busy ignore");
    @(negedge clk);
    in_count = pack(7, 9, 4, 11); win_len = 60; threshold = 12; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    wr_en = 1; wr_row = 1; wr_col = 0; wr_val = 0;
    in_count = pack(30, 30, 30, 30); win_len = 10; threshold = 1; start = 1;
    @(negedge clk);
    wr_en = 0; start = 0;
    wait_idle();
    run(60, 12, pack(7, 9, 4, 11), "R1 weight kept");

    repeat (5) @(negedge clk);
    check("R7 queue drained", q_t.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule